// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a small multicycle processor core. Each instruction takes a different number of clock cycles, depending on its class. The block reads the 4-bit opcode held in the instruction register. Each cycle, it drives the strobes that load the instruction register, advance the program counter and write the register file. It also drives the operand selects and the operation code of the shared ALU, and the select that picks between the ALU result and the zero-extended immediate at write-back.

The state is kept as a one-hot vector with five states: fetch, decode, execute, register write-back and immediate write-back. The instruction class is resolved in the decode cycle:

- Register-type instructions take four cycles.
- Load-immediate instructions take three cycles.
- No-operation instructions take two cycles.

After the last state of every class, the machine returns to fetch. Whenever a control output has no meaning in a state, it is driven to 0.

Top module: `mcf_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the machine is placed in fetch. In the first cycle after `rst` falls, the outputs show the fetch pattern.
- R2: In fetch, `ir_load`=1, `pc_load`=1, `rf_write`=0, `alu_a_sel`=1 (program counter), `alu_b_sel`=1 (constant one), `alu_op`=3'b000 (add) and `wb_imm_sel`=0. This holds whatever the opcode input is.
- R3: Fetch is always followed by decode. In decode, all seven outputs are 0.
- R4: An opcode with bit 3 clear is register-type. Its sequence is fetch, decode, execute, register write-back, which is 4 cycles. In execute, `alu_a_sel`=0, `alu_b_sel`=0, `alu_op` equals opcode bits [2:0], and all three strobes are 0.
- R5: In register write-back, `rf_write`=1 and `wb_imm_sel`=0. All other outputs are 0.
- R6: Opcode 4'b1000 is load-immediate. Its sequence is fetch, decode, immediate write-back, which is 3 cycles. The write-back cycle has `rf_write`=1 and `wb_imm_sel`=1, and all other outputs are 0.
- R7: Opcode 4'b1100 is no-operation. Its sequence is fetch then decode (2 cycles), and it never asserts `rf_write`.
- R8: Any other opcode with bit 3 set (for example 4'b1111 or 4'b1010) behaves exactly like no-operation.
- R9: The class is taken from the opcode present in the decode cycle. A change of opcode during a write-back cycle does not change that cycle's outputs or the return to fetch.
- R10: Exactly one state is active at all times, and `ir_load` and `rf_write` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| ir_load | output | 1 | Load the instruction register |
| pc_load | output | 1 | Load the program counter |
| rf_write | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU first operand: 1 = program counter, 0 = register A |
| alu_b_sel | output | 1 | ALU second operand: 1 = constant one, 0 = register B |
| alu_op | output | 3 | ALU operation code |
| wb_imm_sel | output | 1 | Write-back data: 1 = zero-extended immediate, 0 = ALU result |

## Verification
Two functions share the `alu_op` output: the fixed add used for the program-counter increment in fetch, and the pass-through of opcode bits [2:0] in execute. To provoke a conflict, a register-type opcode with all low bits set (3'b111) is applied before and during the fetch cycle. The bench then expects 3'b000 in fetch and 3'b111 two cycles later in execute. The instruction that follows is fetched in the cycle right after write-back, so the same opcode value stays at the input through that next fetch. The bench also checks that the fetch pattern wins in that cycle.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 3;
    localparam int NUM_ST  = 5;

    // one-hot bit positions of the state vector
    localparam int S_FETCH = 0;
    localparam int S_DEC   = 1;
    localparam int S_EXEC  = 2;
    localparam int S_WBR   = 3;
    localparam int S_WBI   = 4;

    typedef logic [NUM_ST-1:0]  st_vec_t;
    typedef logic [OPC_W-1:0]   opc_t;
    typedef logic [ALUOP_W-1:0] aluop_t;

    typedef enum logic [1:0] {
        CLS_REG  = 2'd0,
        CLS_IMM  = 2'd1,
        CLS_IDLE = 2'd2
    } cls_e;

    typedef struct packed {
        logic   ir_load;
        logic   pc_load;
        logic   rf_write;
        logic   a_sel;
        logic   b_sel;
        aluop_t alu_op;
        logic   imm_sel;
    } ctrl_t;

    localparam opc_t   OPC_LI   = 4'b1000;
    localparam opc_t   OPC_NOP  = 4'b1100;
    localparam aluop_t ALU_ADD  = '0;

    function automatic st_vec_t st_only(input int idx);
        st_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mcf_classify.sv
module mcf_classify
    import mcf_pkg::*;
(
    input  opc_t opcode,
    output cls_e cls
);
    always_comb begin
        if (!opcode[OPC_W-1])
            cls = CLS_REG;
        else if (opcode == OPC_LI)
            cls = CLS_IMM;
        else
            cls = CLS_IDLE;   // explicit no-op and every other opcode with top bit set
    end
endmodule

// File: rtl/mcf_next_state.sv
module mcf_next_state
    import mcf_pkg::*;
(
    input  st_vec_t st,
    input  cls_e    cls,
    output st_vec_t nxt
);
    logic dec_reg, dec_imm, dec_idle;

    always_comb begin
        dec_reg  = st[S_DEC] && (cls == CLS_REG);
        dec_imm  = st[S_DEC] && (cls == CLS_IMM);
        dec_idle = st[S_DEC] && (cls == CLS_IDLE);

        nxt          = '0;
        nxt[S_FETCH] = st[S_WBR] | st[S_WBI] | dec_idle | ~(|st);
        nxt[S_DEC]   = st[S_FETCH];
        nxt[S_EXEC]  = dec_reg;
        nxt[S_WBR]   = st[S_EXEC];
        nxt[S_WBI]   = dec_imm;
    end
endmodule

// File: rtl/mcf_out_decode.sv
module mcf_out_decode
    import mcf_pkg::*;
(
    input  st_vec_t st,
    input  aluop_t  op_low,
    output ctrl_t   ctl
);
    always_comb begin
        ctl = '0;
        if (st[S_FETCH]) begin
            ctl.ir_load = 1'b1;
            ctl.pc_load = 1'b1;
            ctl.a_sel   = 1'b1;
            ctl.b_sel   = 1'b1;
            ctl.alu_op  = ALU_ADD;
        end
        if (st[S_EXEC]) begin
            ctl.alu_op  = op_low;
        end
        if (st[S_WBR] || st[S_WBI]) begin
            ctl.rf_write = 1'b1;
        end
        if (st[S_WBI]) begin
            ctl.imm_sel = 1'b1;
        end
    end
endmodule

// File: rtl/mcf_ctrl.sv
module mcf_ctrl
    import mcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opcode,
    output logic       ir_load,
    output logic       pc_load,
    output logic       rf_write,
    output logic       alu_a_sel,
    output logic       alu_b_sel,
    output logic [2:0] alu_op,
    output logic       wb_imm_sel
);
    st_vec_t st_q, st_d;
    cls_e    cls;
    ctrl_t   ctl;

    mcf_classify u_cls (
        .opcode (opcode),
        .cls    (cls)
    );

    mcf_next_state u_nxt (
        .st  (st_q),
        .cls (cls),
        .nxt (st_d)
    );

    mcf_out_decode u_out (
        .st     (st_q),
        .op_low (opcode[ALUOP_W-1:0]),
        .ctl    (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= st_only(S_FETCH);
        else
            st_q <= st_d;
    end

    assign ir_load    = ctl.ir_load;
    assign pc_load    = ctl.pc_load;
    assign rf_write   = ctl.rf_write;
    assign alu_a_sel  = ctl.a_sel;
    assign alu_b_sel  = ctl.b_sel;
    assign alu_op     = ctl.alu_op;
    assign wb_imm_sel = ctl.imm_sel;

    // R10: state vector stays one-hot
    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q) == 1);

    // R10: no instruction load during a register write
    p_no_ir_rf_clash_r10: assert property (@(posedge clk) disable iff (rst)
        !(ir_load && rf_write));

    // R3: a fetch cycle is followed by an all-quiet decode cycle
    p_fetch_then_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (!ir_load && !pc_load && !rf_write));

    // R4: execute uses register operands
    p_exec_regs_r4: assert property (@(posedge clk) disable iff (rst)
        st_q[S_EXEC] |-> (!alu_a_sel && !alu_b_sel));

    // R6: load-immediate in decode leads to immediate write-back
    p_li_wb_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q[S_DEC] && opcode == OPC_LI) |=> (rf_write && wb_imm_sel));

    // R7: no-op in decode returns straight to fetch
    p_nop_return_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q[S_DEC] && opcode == OPC_NOP) |=> (ir_load && !rf_write));

    // R5: every write-back is followed by a fetch
    p_wb_then_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        rf_write |=> ir_load);
endmodule

// File: tb/mcf_ctrl_tb_top.sv
module mcf_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam int ST_F  = 0;
    localparam int ST_D  = 1;
    localparam int ST_E  = 2;
    localparam int ST_WR = 3;
    localparam int ST_WI = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'b0000;
    logic       ir_load, pc_load, rf_write, alu_a_sel, alu_b_sel, wb_imm_sel;
    logic [2:0] alu_op;

    int n_run  = 0;
    int n_fail = 0;

    mcf_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .ir_load    (ir_load),
        .pc_load    (pc_load),
        .rf_write   (rf_write),
        .alu_a_sel  (alu_a_sel),
        .alu_b_sel  (alu_b_sel),
        .alu_op     (alu_op),
        .wb_imm_sel (wb_imm_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // packed order: ir pc rf a b op[2:0] imm
    function automatic logic [8:0] expect_vec(input int stg, input logic [3:0] opc);
        case (stg)
            ST_F:    return {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0};
            ST_E:    return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, opc[2:0], 1'b0};
            ST_WR:   return {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0};
            ST_WI:   return {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1};
            default: return 9'b0;
        endcase
    endfunction

    task automatic check(input int stg, input string tag);
        logic [8:0] act, exp;
        act = {ir_load, pc_load, rf_write, alu_a_sel, alu_b_sel, alu_op, wb_imm_sel};
        exp = expect_vec(stg, opcode);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s stage=%0d actual=%b expected=%b", tag, stg, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // run one instruction starting at a fetch cycle; returns at the next fetch
    task automatic run_instr(input logic [3:0] opc, input string tag);
        opcode = opc;
        check(ST_F, {tag, " R2 fetch"});
        step();
        check(ST_D, {tag, " R3 decode"});
        step();
        if (!opc[3]) begin
            check(ST_E, {tag, " R4 execute"});
            step();
            check(ST_WR, {tag, " R5 reg wb"});
            step();
        end else if (opc == 4'b1000) begin
            check(ST_WI, {tag, " R6 imm wb"});
            step();
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        opcode = 4'b0111;
        step();
        step();
        rst = 1'b0;
        check(ST_F, "R1 reset state");
    endtask

    task automatic t_reg_types;
        run_instr(4'b0000, "R4 add");
        run_instr(4'b0001, "R4 sub");
        run_instr(4'b0101, "R4 nand");
        check(ST_F, "R4 back to fetch");
    endtask

    task automatic t_shared_op;
        // R2/R4: op 111 present in fetch must not leak into fetch alu_op
        run_instr(4'b0111, "R2 R4 shared alu_op");
        opcode = 4'b0111;
        check(ST_F, "R2 fetch after wb with op 111");
    endtask

    task automatic t_li;
        run_instr(4'b1000, "R6 li");
        check(ST_F, "R6 3-cycle return");
    endtask

    task automatic t_nops;
        run_instr(4'b1100, "R7 nop");
        check(ST_F, "R7 2-cycle return");
        run_instr(4'b1111, "R8 op1111");
        check(ST_F, "R8 op1111 return");
        run_instr(4'b1010, "R8 op1010");
        check(ST_F, "R8 op1010 return");
    endtask

    task automatic t_late_change;
        opcode = 4'b1000;
        check(ST_F, "R9 fetch");
        step();
        check(ST_D, "R9 decode");
        step();
        opcode = 4'b1100;   // change during write-back
        check(ST_WI, "R9 imm wb held");
        step();
        check(ST_F, "R9 return to fetch");
        opcode = 4'b0010;
        step();
        check(ST_D, "R9 decode of reg op");
        step();
        opcode = 4'b1111;   // change during execute is seen only on alu_op
        step();
        opcode = 4'b1100;
        check(ST_WR, "R9 reg wb held");
        step();
        check(ST_F, "R9 fetch after reg wb");
    endtask

    task automatic t_exclusive;
        // R10: ir_load and rf_write never together across a mixed stream
        for (int i = 0; i < 24; i++) begin
            opcode = 4'(i * 5);
            n_run++;
            if (ir_load && rf_write) begin
                n_fail++;
                $display("FAIL R10 ir/rf clash actual=11 expected=not both");
            end
            step();
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_reg_types();
        t_shared_op();
        t_li();
        t_nops();
        t_late_change();
        t_exclusive();
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(ST_F, "R1 reset mid-stream");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule